// File: doc/BRIEF.md
# Four-Phase Multiplexed LCD Segment Driver

This block drives a liquid-crystal panel whose segments are multiplexed over four backplane phases. A host streams segment bits over a two-wire serial link made of a data line and a data clock. Each frame starts with an eight-bit address field and carries 128 segment bits, one bit for each segment. Several drivers can sit on the same link. A rising edge on a strobe input copies the received bits into a display latch, but only in the driver whose three strap pins match the address field and only if the frame had exactly the right length. No character decoding is done here, so every bit pattern is formatted upstream.

The latch is scanned continuously. A prescaler derived from the system clock steps a phase counter through the four backplane phases. For each phase, one backplane output is active and 32 frontplane outputs show the latch bits of that phase as digital on/off levels. Cascaded drivers stay in step through a frame-sync line. The driver strapped as master pulses this line as its scan re-enters phase 0. Drivers strapped as slaves restart their scan when they see the pulse. Analog drive levels and the oscillator are outside this block.

The serial inputs are assumed to be synchronous to `clk` and to hold each level for at least one clock cycle.

Top module: `lcd_quad_mux_driver`

## Requirements
- R1: While reset is held and after it is released, the latch is all zero, the phase is 0 (`bp_out` = 4'b0001) and `fsync_out` is low.
- R2: A bit is taken from `ser_data` at each rising edge of `ser_clk`. Within a frame the first 8 bits form the address field and the next 128 are segment bits. Both are sent most significant bit first, so the first segment bit lands in segment 127.
- R3: On a rising edge of `strobe`, the latch loads the segment bits if both of the following hold: exactly 136 bits arrived since the previous strobe, and the low 3 bits of the address field equal `addr_strap`. The upper 5 address bits are ignored.
- R4: A strobe that follows 135 bits, 137 bits, or a frame whose address does not match leaves the latch unchanged.
- R5: Each strobe edge restarts the bit count, so the frame after it is judged on its own. A strobe with no bits before it changes nothing.
- R6: The phase steps 0→1→2→3→0 once every TICK_DIV clock cycles. `bp_out` is one-hot, with the bit set at the position of the phase.
- R7: `fp_out[k]` equals latch bit `phase*32 + k`.
- R8: With `sync_master` high, `fsync_out` is high for exactly one cycle, the cycle in which the phase has just become 0. `fsync_in` is ignored in this mode.
- R9: With `sync_master` low, `fsync_in` high forces the phase to 0 at the next clock edge, and the following step comes TICK_DIV-1 cycles later, in step with the master. `fsync_out` stays low in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial data clock; bit taken on its rising edge |
| strobe | input | 1 | Transfer request; acts on its rising edge |
| addr_strap | input | 3 | Device address strap |
| sync_master | input | 1 | 1 = generate frame sync, 0 = follow frame sync |
| fsync_in | input | 1 | Frame-sync pulse from the master driver |
| fsync_out | output | 1 | Frame-sync pulse to slave drivers |
| bp_out | output | 4 | One-hot backplane phase select |
| fp_out | output | 32 | Frontplane on/off states for the active phase |

## Verification
The hardest case to reach from the ports is a slave resync. The pulse has to land in a phase other than 0, and the check has to show both the jump to phase 0 and the shortened first interval that puts the slave back in step with the master's prescaler. The bench waits, by watching `bp_out`, until the scan has just entered phase 2, raises `fsync_in` for one cycle, and then counts cycles to the next step. Frames that are one bit too short or too long are built by the same frame task with a different bit count. A partial frame cut off by a strobe and followed by a full frame shows that the count restarts.

// File: rtl/lcd_drv_pkg.sv
// Package: shared constants for the quad-multiplexed LCD driver.
// Assumes: consumers take these as parameter defaults only.
package lcd_drv_pkg;
    localparam int unsigned DEF_FP_N     = 32;  // frontplanes per phase
    localparam int unsigned DEF_BP_N     = 4;   // backplane phases
    localparam int unsigned DEF_STRAP_W  = 3;   // address strap width
    localparam int unsigned ADDR_FIELD_W = 8;   // address field length in a frame
    localparam int unsigned DEF_TICK_DIV = 8;   // clock cycles per phase
endpackage

// File: rtl/lcd_serial_rx.sv
// Module: lcd_serial_rx
// Receives a serial frame (address field, then segment bits, MSB first),
// counts bits since the last strobe, and raises load for one cycle on a
// strobe edge when the count is exact and the address matches the strap.
// Assumes: ser_clk, ser_data and strobe are synchronous to clk.
module lcd_serial_rx #(
    parameter int unsigned SEG_N   = 128,
    parameter int unsigned STRAP_W = 3,
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               strobe,
    input  logic [STRAP_W-1:0] strap,
    output logic               load,
    output logic [SEG_N-1:0]   seg_word
);
    localparam int unsigned FRAME_BITS = FIELD_W + SEG_N;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] SAT_CNT   = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FIELD_CNT = CNT_W'(FIELD_W);

    logic               sclk_q, stb_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FIELD_W-1:0] addr_sr;
    logic [SEG_N-1:0]   data_sr;
    logic               sclk_rise, stb_rise;

    // Edge detection on the serial clock and the strobe.
    assign sclk_rise = ser_clk & ~sclk_q;
    assign stb_rise  = strobe & ~stb_q;

    // Shift address and segment bits, count bits, restart on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            stb_q   <= 1'b0;
            bit_cnt <= '0;
            addr_sr <= '0;
            data_sr <= '0;
        end else begin
            sclk_q <= ser_clk;
            stb_q  <= strobe;
            if (stb_rise) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                if (bit_cnt < SAT_CNT) bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt < FIELD_CNT)
                    addr_sr <= {addr_sr[FIELD_W-2:0], ser_data};
                else if (bit_cnt < FULL_CNT)
                    data_sr <= {data_sr[SEG_N-2:0], ser_data};
            end
        end
    end

    // Transfer request: exact frame length and matching address.
    assign load     = stb_rise && (bit_cnt == FULL_CNT) && (addr_sr[STRAP_W-1:0] == strap);
    assign seg_word = data_sr;

    // R4: the bit counter saturates one past a full frame.
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= SAT_CNT);
    // R5: a strobe edge always leaves the counter at zero.
    a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !stb_q) |=> (bit_cnt == '0));
endmodule

// File: rtl/lcd_phase_scan.sv
// Module: lcd_phase_scan
// Prescales the system clock into phase ticks, cycles the backplane
// phase, and generates or follows the frame-sync pulse.
// Assumes: TICK_DIV >= 2; fsync_in is synchronous to clk.
module lcd_phase_scan #(
    parameter int unsigned BP_N     = 4,
    parameter int unsigned TICK_DIV = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    is_master,
    input  logic                    fsync_in,
    output logic [$clog2(BP_N)-1:0] phase,
    output logic                    fsync_out
);
    localparam int unsigned PH_W  = $clog2(BP_N);
    localparam int unsigned DIV_W = $clog2(TICK_DIV);
    localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(TICK_DIV - 1);
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(BP_N - 1);

    logic [DIV_W-1:0] presc;
    logic             tick, sync_hit;

    assign tick     = (presc == LAST_DIV);
    assign sync_hit = !is_master && fsync_in;

    // Prescaler, phase counter and master sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc     <= '0;
            phase     <= '0;
            fsync_out <= 1'b0;
        end else if (sync_hit) begin
            presc     <= DIV_W'(1);
            phase     <= '0;
            fsync_out <= 1'b0;
        end else begin
            fsync_out <= is_master && tick && (phase == LAST_PH);
            if (tick) begin
                presc <= '0;
                phase <= (phase == LAST_PH) ? '0 : phase + PH_W'(1);
            end else begin
                presc <= presc + DIV_W'(1);
            end
        end
    end

    // R6: without a resync the phase only moves forward by one.
    a_r6_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != $past(phase)) && !$past(sync_hit)) |->
        (phase == (($past(phase) == LAST_PH) ? '0 : $past(phase) + PH_W'(1))));
    // R8: the sync pulse lasts one cycle and marks phase 0.
    a_r8_fsync_single: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_out |=> !fsync_out);
    a_r8_fsync_phase0: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_out |-> (phase == '0));
    // R9: a slave seeing sync restarts at phase 0 without echoing the pulse.
    a_r9_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> ((phase == '0) && !fsync_out));
endmodule

// File: rtl/lcd_fp_mux.sv
// Module: lcd_fp_mux
// Selects the frontplane word of the active phase from the latch and
// decodes the phase into one-hot backplane selects.
// Assumes: phase < BP_N.
module lcd_fp_mux #(
    parameter int unsigned FP_N = 32,
    parameter int unsigned BP_N = 4
) (
    input  logic [FP_N*BP_N-1:0]   seg_word,
    input  logic [$clog2(BP_N)-1:0] phase,
    output logic [FP_N-1:0]        fp_out,
    output logic [BP_N-1:0]        bp_out
);
    localparam int unsigned PH_W = $clog2(BP_N);

    logic [FP_N-1:0] words [BP_N];

    // Split the latch per phase and decode each backplane select.
    for (genvar g = 0; g < BP_N; g++) begin : g_phase
        assign words[g]  = seg_word[g*FP_N +: FP_N];
        assign bp_out[g] = (phase == PH_W'(g));
    end

    // Drive the frontplanes from the active phase's word.
    assign fp_out = words[phase];
endmodule

// File: rtl/lcd_quad_mux_driver.sv
// Module: lcd_quad_mux_driver (top)
// Serially loaded, address-strapped LCD driver: receiver, display latch,
// phase scanner and frontplane multiplexer.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module lcd_quad_mux_driver
    import lcd_drv_pkg::*;
#(
    parameter int unsigned FP_N     = DEF_FP_N,
    parameter int unsigned BP_N     = DEF_BP_N,
    parameter int unsigned STRAP_W  = DEF_STRAP_W,
    parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               strobe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic               sync_master,
    input  logic               fsync_in,
    output logic               fsync_out,
    output logic [BP_N-1:0]    bp_out,
    output logic [FP_N-1:0]    fp_out
);
    localparam int unsigned SEG_N = FP_N * BP_N;
    localparam int unsigned PH_W  = $clog2(BP_N);

    logic             load;
    logic [SEG_N-1:0] rx_word, seg_q;
    logic [PH_W-1:0]  phase;

    lcd_serial_rx #(.SEG_N(SEG_N), .STRAP_W(STRAP_W), .FIELD_W(ADDR_FIELD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .strobe(strobe), .strap(addr_strap), .load(load), .seg_word(rx_word)
    );

    // Display latch: cleared at reset, loaded on an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    seg_q <= '0;
        else if (load) seg_q <= rx_word;
    end

    lcd_phase_scan #(.BP_N(BP_N), .TICK_DIV(TICK_DIV)) u_scan (
        .clk(clk), .rst_n(rst_n), .is_master(sync_master), .fsync_in(fsync_in),
        .phase(phase), .fsync_out(fsync_out)
    );

    lcd_fp_mux #(.FP_N(FP_N), .BP_N(BP_N)) u_mux (
        .seg_word(seg_q), .phase(phase), .fp_out(fp_out), .bp_out(bp_out)
    );

    // R3/R4: the latch holds unless the receiver accepted a transfer.
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(seg_q));
    // R6: exactly one backplane is active.
    a_r6_bp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(bp_out));
endmodule

// File: tb/test_lcd_quad_mux_driver.sv
`timescale 1ns/1ps
module test_lcd_quad_mux_driver;
    localparam int TD    = 8;
    localparam int FPN   = 32;
    localparam int BPN   = 4;
    localparam logic [2:0] STRAP = 3'b101;
    localparam int NVEC  = 7;
    // Vector: {address field, data seed, total bits sent}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h05, 32'h1234_5678, 8'd136},
        {8'hF5, 32'hDEAD_BEEF, 8'd136},
        {8'h04, 32'h0F0F_0F0F, 8'd136},
        {8'h05, 32'hFFFF_0000, 8'd135},
        {8'h05, 32'h8000_0001, 8'd137},
        {8'h0D, 32'hA5A5_5A5A, 8'd136},
        {8'h07, 32'h1111_1111, 8'd136}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, strobe = 1'b0;
    logic sync_master = 1'b1, fsync_in = 1'b0;
    logic fsync_out;
    logic [BPN-1:0] bp_out;
    logic [FPN-1:0] fp_out;
    int checks = 0, fails = 0;
    logic [127:0] model = '0;

    always #2.5 clk = ~clk;

    lcd_quad_mux_driver #(.TICK_DIV(TD)) i_lcd_quad_mux_driver (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .strobe(strobe), .addr_strap(STRAP), .sync_master(sync_master),
        .fsync_in(fsync_in), .fsync_out(fsync_out), .bp_out(bp_out), .fp_out(fp_out)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] make_data(input logic [31:0] s);
        return {s, ~s, {s[15:0], s[31:16]}, s ^ 32'h3C3C_C3C3};
    endfunction

    task automatic send_frame(input logic [7:0] a, input logic [127:0] d, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ser_data = (i < 8) ? a[7-i] : ((i - 8 < 128) ? d[127-(i-8)] : 1'b0);
            ser_clk  = 1'b1;
            @(negedge clk);
            ser_clk  = 1'b0;
        end
    endtask

    task automatic pulse_strobe();
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
    endtask

    // Scan all phases and compare frontplanes with the model word.
    task automatic check_phases(input logic [127:0] exp, input string req);
        bit ok = 1'b1;
        logic [31:0] bad_act = '0, bad_exp = '0;
        repeat (BPN * TD) begin
            @(negedge clk);
            if (!$onehot(bp_out)) begin
                ok = 1'b0; bad_act = {28'd0, bp_out};
            end else begin
                for (int p = 0; p < BPN; p++)
                    if (bp_out[p] && fp_out != exp[p*FPN +: FPN]) begin
                        ok = 1'b0; bad_act = fp_out; bad_exp = exp[p*FPN +: FPN];
                    end
            end
        end
        check(ok, req, {96'd0, bad_act}, {96'd0, bad_exp});
    endtask

    task automatic cycles_to_change(output int n);
        logic [BPN-1:0] b0 = bp_out;
        n = 0;
        do begin @(negedge clk); n++; end while (bp_out == b0 && n < 100);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        logic [127:0] d;
        logic [BPN-1:0] prev;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(bp_out == 4'b0001 && fsync_out == 1'b0, "R1 reset outputs", {bp_out, fsync_out}, {4'b0001, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check(fsync_out == 1'b0, "R1 fsync after reset", {127'd0, fsync_out}, 128'd0);
        check_phases(128'd0, "R1 R7 latch clear after reset");

        // R2 R7: single bit lands in segment 127 (phase 3, frontplane 31)
        send_frame(8'h05, 128'd1 << 127, 136);
        pulse_strobe();
        model = 128'd1 << 127;
        check_phases(model, "R2 R7 first data bit to segment 127");

        // R3 R4: vector table
        for (int v = 0; v < NVEC; v++) begin
            d = make_data(VEC[v][39:8]);
            send_frame(VEC[v][47:40], d, int'(VEC[v][7:0]));
            pulse_strobe();
            if (VEC[v][42:40] == STRAP && VEC[v][7:0] == 8'd136) model = d;
            check_phases(model, $sformatf("R3 R4 vector %0d", v));
        end

        // R5: strobe alone, then a cut-off frame followed by a full frame
        pulse_strobe();
        check_phases(model, "R5 strobe with no bits");
        send_frame(8'h05, make_data(32'h0BAD_F00D), 100);
        pulse_strobe();
        d = make_data(32'h600D_CAFE);
        send_frame(8'h05, d, 136);
        pulse_strobe();
        model = d;
        check_phases(model, "R5 count restarts after strobe");

        // R6 R8: master mode period, sequence and sync pulse
        sync_master = 1'b1;
        prev = bp_out;
        do begin prev = bp_out; @(negedge clk); end while (!(bp_out == 4'b0001 && prev != 4'b0001));
        check(fsync_out == 1'b1, "R8 sync pulse on entering phase 0", {127'd0, fsync_out}, 128'd1);
        @(negedge clk);
        check(fsync_out == 1'b0, "R8 sync pulse one cycle", {127'd0, fsync_out}, 128'd0);
        cycles_to_change(n);
        check(n == TD - 1, "R6 phase period", n, TD - 1);
        check(bp_out == 4'b0010, "R6 phase order 0 to 1", bp_out, 4'b0010);
        cycles_to_change(n);
        check(n == TD && bp_out == 4'b0100, "R6 full period to phase 2", {n, bp_out}, {TD, 4'b0100});
        fsync_in = 1'b1;
        @(negedge clk);
        fsync_in = 1'b0;
        check(bp_out == 4'b0100, "R8 fsync_in ignored by master", bp_out, 4'b0100);

        // R9: slave resync from phase 2
        sync_master = 1'b0;
        prev = bp_out;
        do begin prev = bp_out; @(negedge clk); end while (!(bp_out == 4'b0100 && prev != 4'b0100));
        fsync_in = 1'b1;
        @(negedge clk);
        fsync_in = 1'b0;
        check(bp_out == 4'b0001 && fsync_out == 1'b0, "R9 slave jumps to phase 0", {bp_out, fsync_out}, {4'b0001, 1'b0});
        cycles_to_change(n);
        check(n == TD - 1, "R9 first step after resync", n, TD - 1);
        n = 0;
        repeat (BPN * TD + 4) begin @(negedge clk); if (fsync_out) n++; end
        check(n == 0, "R9 slave emits no sync", n, 0);
        finish_run();
    end
endmodule